// File: doc/BRIEF.md
# Two-Dimensional DMA Write Address Generator

This block generates the memory side of a capture DMA channel that writes words into memory. Words arrive from a capture source that raises a request while it has data. The block turns each word into a memory write beat that carries an address, the word and per-lane byte enables. Addresses follow two nested loops. The inner loop produces one row of transfers, and the outer loop repeats that row a programmed number of times. Each loop has its own signed byte step.

Software sets the start address, both counts, both steps, a transfer size and a repeat flag, and then raises `enable`. The block checks the configuration on that rising edge and either starts the channel or reports a configuration error. When the repeat flag is set, the channel reloads itself at the end of every frame and keeps overwriting the same buffer. When it is clear, the channel stops after one frame and stays idle until `enable` is lowered and raised again. The configuration must be held stable while the channel is busy.

Top module: `dma2d_wr_agen`

## Requirements
- R1: On a rising edge of `enable` with a valid configuration, `busy` is high from the next clock edge and the first beat's address equals `cfg_start_addr`.
- R2: `mem_valid` is high exactly when `busy`, `enable` and `src_req` are all high. `mem_data` equals `src_data`. `src_ack` is high exactly when `mem_valid` and `mem_ready` are both high. No beat is issued while `src_req` is low.
- R3: After an accepted beat that is not the last of its row, the address advances by the signed `cfg_x_modify`. After the last beat of a row it advances by the signed `cfg_y_modify`. While a beat is stalled by `mem_ready` low, the address holds.
- R4: When the two modifies are equal, beat n of a frame, counting from 0, goes to start + n × modify, which is the same as a linear transfer.
- R5: A row holds `cfg_x_count` beats and a frame holds `cfg_y_count` rows. `row_done` is high for one cycle after the accepted last beat of each row. `frame_done` is high in that same cycle only for the last row of a frame.
- R6: With `cfg_autobuf` low, `busy` falls in the cycle in which `frame_done` is high. After that, `src_req` produces no beat and no `src_ack` until `enable` falls and rises again.
- R7: With `cfg_autobuf` high, after the last beat of a frame `busy` stays high, the counts reload, and the next beat's address equals `cfg_start_addr`.
- R8: `cfg_wsize` encodes 0 as byte, 1 as 16-bit, and 2 or 3 as 32-bit. On the enable edge, any of the following makes `cfg_err` high from the next edge, keeps `busy` low and issues no beats: a start address or either modify that is not a multiple of the size, or a zero count. `cfg_err` clears while `enable` is low.
- R9: `mem_be` (bit i = byte lane i, where lane = address bits [1:0]) is 4'b0001 shifted left by addr[1:0] for byte size. For 16-bit size it is 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. For 32-bit size it is 4'b1111.
- R10: Lowering `enable` during a frame removes `mem_valid` in the same cycle and clears `busy` at the next edge.
- R11: After reset, `busy`, `cfg_err`, `row_done`, `frame_done`, `mem_valid` and `src_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; a rising edge starts a frame sequence |
| cfg_start_addr | input | AW | Byte address of the first beat |
| cfg_x_count | input | CW | Beats per row |
| cfg_x_modify | input | MW | Signed byte step inside a row |
| cfg_y_count | input | CW | Rows per frame |
| cfg_y_modify | input | MW | Signed byte step after the last beat of a row |
| cfg_wsize | input | 2 | Transfer size: 0 byte, 1 16-bit, 2/3 32-bit |
| cfg_autobuf | input | 1 | Reload and repeat after each frame |
| src_req | input | 1 | Source holds a word |
| src_data | input | 32 | Source word |
| src_ack | output | 1 | Word taken from the source |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Write byte address |
| mem_data | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| busy | output | 1 | Channel active |
| cfg_err | output | 1 | Configuration rejected |
| row_done | output | 1 | One-cycle pulse after a row ends |
| frame_done | output | 1 | One-cycle pulse after a frame ends |

## Verification
The end of a row and the end of a frame fall on the same accepted beat. In repeat mode that beat also triggers the reload of the start address and both counts. The bench sweeps every combination of row length 1 to 3 and row count 1 to 3, including the single-beat frame, where all three events fall on every beat. It checks that `row_done` and `frame_done` arrive together in the next cycle, and that the following beat returns to the start address rather than taking the row step. These runs are made both with the source and memory handshakes held high and with random stalls, so that the coincident events are also checked when they follow a stalled beat.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    WS_BYTE = 2'd0,
    WS_HALF = 2'd1,
    WS_WORD = 2'd2,
    WS_WIDE = 2'd3
  } wsize_e;

  // low address bits that must be zero for a given transfer size
  function automatic logic [1:0] size_mask(input wsize_e ws);
    case (ws)
      WS_BYTE: return 2'b00;
      WS_HALF: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic is_aligned(input logic [1:0] lsb, input wsize_e ws);
    return (lsb & size_mask(ws)) == 2'b00;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] lsb, input wsize_e ws);
    case (ws)
      WS_BYTE: return 4'b0001 << lsb;
      WS_HALF: return lsb[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_loop_ctr.sv
module dma2d_loop_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - CW'(1);
  end

  assign last = (count == CW'(1));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          use_y,
  input  logic [MW-1:0] x_mod,
  input  logic [MW-1:0] y_mod,
  output logic [AW-1:0] addr
);

  localparam int EXT = AW - MW;

  logic [AW-1:0] x_ext;
  logic [AW-1:0] y_ext;
  logic [AW-1:0] inc;

  assign x_ext = {{EXT{x_mod[MW-1]}}, x_mod};
  assign y_ext = {{EXT{y_mod[MW-1]}}, y_mod};
  assign inc   = use_y ? y_ext : x_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= load_addr;
    else if (step)  addr <= addr + inc;
  end

endmodule

// File: rtl/dma2d_wr_agen.sv
module dma2d_wr_agen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [AW-1:0]    cfg_start_addr,
  input  logic [CW-1:0]    cfg_x_count,
  input  logic [MW-1:0]    cfg_x_modify,
  input  logic [CW-1:0]    cfg_y_count,
  input  logic [MW-1:0]    cfg_y_modify,
  input  logic [1:0]       cfg_wsize,
  input  logic             cfg_autobuf,
  input  logic             src_req,
  input  logic [DW-1:0]    src_data,
  output logic             src_ack,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  output logic [LANES-1:0] mem_be,
  output logic             busy,
  output logic             cfg_err,
  output logic             row_done,
  output logic             frame_done
);

  wsize_e ws;
  assign ws = wsize_e'(cfg_wsize);

  // named internal events
  logic          en_q;
  logic          en_rise;
  logic          cfg_good;
  logic          start_ok;
  logic          start_bad;
  logic          beat_fire;
  logic          row_end;
  logic          frame_end;
  logic          reload;
  logic          x_last;
  logic          y_last;
  logic [CW-1:0] x_cnt;
  logic [CW-1:0] y_cnt;

  assign en_rise   = enable & ~en_q;
  assign cfg_good  = is_aligned(cfg_start_addr[1:0], ws)
                   & is_aligned(cfg_x_modify[1:0], ws)
                   & is_aligned(cfg_y_modify[1:0], ws)
                   & (cfg_x_count != '0)
                   & (cfg_y_count != '0);
  assign start_ok  = en_rise & cfg_good;
  assign start_bad = en_rise & ~cfg_good;

  assign mem_valid = busy & enable & src_req;
  assign beat_fire = mem_valid & mem_ready;
  assign src_ack   = beat_fire;
  assign row_end   = beat_fire & x_last;
  assign frame_end = row_end & y_last;
  assign reload    = frame_end & cfg_autobuf;

  assign mem_data  = src_data;
  assign mem_be    = lane_mask(mem_addr[1:0], ws);

  dma2d_loop_ctr #(.CW(CW)) u_xctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok | row_end),
    .load_val (cfg_x_count),
    .dec      (beat_fire),
    .count    (x_cnt),
    .last     (x_last)
  );

  dma2d_loop_ctr #(.CW(CW)) u_yctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok | reload),
    .load_val (cfg_y_count),
    .dec      (row_end),
    .count    (y_cnt),
    .last     (y_last)
  );

  dma2d_addr_gen #(.AW(AW), .MW(MW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok | reload),
    .load_addr (cfg_start_addr),
    .step      (beat_fire),
    .use_y     (x_last),
    .x_mod     (cfg_x_modify),
    .y_mod     (cfg_y_modify),
    .addr      (mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      busy       <= 1'b0;
      cfg_err    <= 1'b0;
      row_done   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      en_q       <= enable;
      row_done   <= row_end;
      frame_done <= frame_end;
      if (start_ok)                       busy <= 1'b1;
      else if (!enable)                   busy <= 1'b0;
      else if (frame_end && !cfg_autobuf) busy <= 1'b0;
      if (!enable)        cfg_err <= 1'b0;
      else if (start_bad) cfg_err <= 1'b1;
      else if (start_ok)  cfg_err <= 1'b0;
    end
  end

endmodule

// File: rtl/dma2d_agen_chk.sv
module dma2d_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [AW-1:0] cfg_start_addr,
  input logic [1:0]    cfg_wsize,
  input logic          cfg_autobuf,
  input logic          src_req,
  input logic          src_ack,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          cfg_err,
  input logic          row_done,
  input logic          frame_done,
  input logic          frame_end
);

  AST_VALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (busy && enable && src_req)); // R2

  AST_ACK_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack |-> (mem_valid && mem_ready)); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (!mem_valid || $stable(mem_addr))); // R3

  AST_FRAME_WITH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> row_done); // R5

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cfg_autobuf) |-> !busy); // R6

  AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cfg_autobuf && enable) |=> (busy && mem_addr == cfg_start_addr)); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !mem_valid)); // R8

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && cfg_wsize[1]) |-> (mem_addr[1:0] == 2'b00)); // R8

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy); // R10

endmodule

bind dma2d_wr_agen dma2d_agen_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .cfg_start_addr (cfg_start_addr),
  .cfg_wsize      (cfg_wsize),
  .cfg_autobuf    (cfg_autobuf),
  .src_req        (src_req),
  .src_ack        (src_ack),
  .mem_valid      (mem_valid),
  .mem_ready      (mem_ready),
  .mem_addr       (mem_addr),
  .busy           (busy),
  .cfg_err        (cfg_err),
  .row_done       (row_done),
  .frame_done     (frame_done),
  .frame_end      (frame_end)
);

// File: tb/dma2d_wr_agen_test.sv
module dma2d_wr_agen_test;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int MW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [AW-1:0] cfg_start_addr = '0;
  logic [CW-1:0] cfg_x_count = '0;
  logic [MW-1:0] cfg_x_modify = '0;
  logic [CW-1:0] cfg_y_count = '0;
  logic [MW-1:0] cfg_y_modify = '0;
  logic [1:0]    cfg_wsize = '0;
  logic          cfg_autobuf = 1'b0;
  logic          src_req = 1'b0;
  logic [31:0]   src_data = '0;
  logic          src_ack;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;
  logic [3:0]    mem_be;
  logic          busy;
  logic          cfg_err;
  logic          row_done;
  logic          frame_done;

  dma2d_wr_agen #(.AW(AW), .CW(CW), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_start_addr(cfg_start_addr), .cfg_x_count(cfg_x_count),
    .cfg_x_modify(cfg_x_modify), .cfg_y_count(cfg_y_count),
    .cfg_y_modify(cfg_y_modify), .cfg_wsize(cfg_wsize),
    .cfg_autobuf(cfg_autobuf), .src_req(src_req), .src_data(src_data),
    .src_ack(src_ack), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .busy(busy), .cfg_err(cfg_err), .row_done(row_done), .frame_done(frame_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] a, input int ws);
    if (ws == 0) return 4'(1 << a);
    if (ws == 1) return a[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  task automatic run_case(input logic [31:0] start, input int xc, input int xm,
                          input int yc, input int ym, input int ws,
                          input bit ab, input int nfr, input bit stall);
    int r = 0;
    int c = 0;
    int fr = 0;
    bit pr = 0;
    bit pf = 0;
    bit done = 0;
    bit rq;
    bit rd;
    longint ea;
    @(negedge clk);
    enable = 0; src_req = 0; mem_ready = 0;
    cfg_start_addr = start; cfg_x_count = CW'(xc); cfg_x_modify = MW'(xm);
    cfg_y_count = CW'(yc); cfg_y_modify = MW'(ym); cfg_wsize = 2'(ws);
    cfg_autobuf = ab;
    @(negedge clk);
    enable = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    chk(cfg_err === 1'b0, "R8 no error on valid config", cfg_err, 0);
    chk(mem_addr === start, "R1 first address", mem_addr, start);
    while (!done) begin
      chk(row_done === pr, "R5 row_done", row_done, pr);
      chk(frame_done === pf, "R5 frame_done", frame_done, pf);
      pr = 0; pf = 0;
      lf_step();
      rq = stall ? lf[0] : 1'b1;
      rd = stall ? (lf[3] | lf[5]) : 1'b1;
      src_req = rq; mem_ready = rd;
      src_data = {lf, lf ^ 16'h5A5A};
      #1;
      chk(mem_valid === rq, "R2 mem_valid", mem_valid, rq);
      if (rq) begin
        ea = longint'(start) + longint'(r) * (longint'(xc - 1) * xm + ym) + longint'(c) * xm;
        chk(mem_addr === ea[31:0], "R3 address", mem_addr, ea[31:0]);
        if (xm == ym) begin
          ea = longint'(start) + longint'(r * xc + c) * xm;
          chk(mem_addr === ea[31:0], "R4 linear address", mem_addr, ea[31:0]);
        end
        chk(mem_be === exp_be(ea[1:0], ws), "R9 byte enables", mem_be, exp_be(ea[1:0], ws));
        chk(mem_data === src_data, "R2 data passthrough", mem_data, src_data);
        chk(src_ack === rd, "R2 src_ack", src_ack, rd);
        if (rd) begin
          if (c == xc - 1) begin
            pr = 1; c = 0;
            if (r == yc - 1) begin
              pf = 1; r = 0; fr++;
              if (fr == nfr) done = 1;
            end else r++;
          end else c++;
        end
      end else begin
        chk(src_ack === 1'b0, "R2 no ack without request", src_ack, 0);
      end
      @(negedge clk);
    end
    chk(row_done === pr, "R5 final row_done", row_done, pr);
    chk(frame_done === pf, "R5 final frame_done", frame_done, pf);
    if (ab) begin
      chk(busy === 1'b1, "R7 busy kept after frame", busy, 1);
      chk(mem_addr === start, "R7 reload start address", mem_addr, start);
    end else begin
      chk(busy === 1'b0, "R6 busy cleared with frame_done", busy, 0);
      src_req = 1; mem_ready = 1;
      for (int k = 0; k < 3; k++) begin
        #1;
        chk(mem_valid === 1'b0, "R6 no beat after one-shot frame", mem_valid, 0);
        chk(src_ack === 1'b0, "R6 no ack after one-shot frame", src_ack, 0);
        @(negedge clk);
      end
    end
    enable = 0; src_req = 0; mem_ready = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R10 idle after enable low", busy, 0);
  endtask

  task automatic err_case(input logic [31:0] start, input int xc, input int xm,
                          input int yc, input int ym, input int ws);
    @(negedge clk);
    enable = 0;
    cfg_start_addr = start; cfg_x_count = CW'(xc); cfg_x_modify = MW'(xm);
    cfg_y_count = CW'(yc); cfg_y_modify = MW'(ym); cfg_wsize = 2'(ws);
    cfg_autobuf = 0;
    @(negedge clk);
    enable = 1; src_req = 1; mem_ready = 1;
    @(negedge clk);
    chk(cfg_err === 1'b1, "R8 error flag", cfg_err, 1);
    chk(busy === 1'b0, "R8 stays idle", busy, 0);
    for (int k = 0; k < 2; k++) begin
      #1;
      chk(mem_valid === 1'b0, "R8 no beat on bad config", mem_valid, 0);
      @(negedge clk);
    end
    enable = 0; src_req = 0;
    @(negedge clk);
    chk(cfg_err === 1'b0, "R8 error clears with enable low", cfg_err, 0);
  endtask

  initial begin
    int sz;
    int xm;
    int ym;
    logic [31:0] st;
    #1;
    chk(busy === 1'b0, "R11 reset busy", busy, 0);
    chk(cfg_err === 1'b0, "R11 reset cfg_err", cfg_err, 0);
    chk(row_done === 1'b0 && frame_done === 1'b0, "R11 reset pulses", {row_done, frame_done}, 0);
    chk(mem_valid === 1'b0 && src_ack === 1'b0, "R11 reset handshake", {mem_valid, src_ack}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;

    for (int ws = 0; ws < 3; ws++)
      for (int xc = 1; xc <= 3; xc++)
        for (int yc = 1; yc <= 3; yc++)
          for (int xs = 0; xs < 2; xs++)
            for (int ys = 0; ys < 3; ys++) begin
              sz = 1 << ws;
              xm = (xs == 0) ? sz : 2 * sz;
              ym = (ys == 0) ? xm : (ys == 1) ? 5 * sz : -2 * sz;
              st = 32'h1000 + ((ws == 0) ? 3 : (ws == 1) ? 2 : 8);
              run_case(st, xc, xm, yc, ym, ws, bit'((xc + yc + ys) % 2),
                       ((xc + yc + ys) % 2 == 1) ? 2 : 1, bit'((xs + ys) % 2));
            end

    // rejected configurations
    err_case(32'h1002, 2, 4, 2, 4, 2);
    err_case(32'h1001, 2, 2, 2, 2, 1);
    err_case(32'h1000, 2, 2, 2, 4, 2);
    err_case(32'h1000, 2, 2, 2, 3, 1);
    err_case(32'h1000, 0, 1, 2, 1, 0);
    err_case(32'h1000, 2, 1, 0, 1, 0);
    err_case(32'h1003, 2, 4, 2, 4, 3);

    // abort in the middle of a frame
    @(negedge clk);
    cfg_start_addr = 32'h2000; cfg_x_count = 3; cfg_x_modify = 4;
    cfg_y_count = 3; cfg_y_modify = 4; cfg_wsize = 2; cfg_autobuf = 0;
    enable = 1;
    @(negedge clk);
    src_req = 1; mem_ready = 1;
    repeat (2) @(negedge clk);
    enable = 0;
    #1;
    chk(mem_valid === 1'b0, "R10 beat dropped on enable low", mem_valid, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R10 busy cleared after abort", busy, 0);
    src_req = 0; mem_ready = 0;
    run_case(32'h2000, 3, 4, 3, 4, 2, 1'b0, 1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule